// File: doc/BRIEF.md
# Compare Flag Generator

This unit compares two operands held in 64-bit register entries and turns the outcome into a 32-bit status word. A host processor moves that word into its own condition flags. Four comparison kinds are offered: 32-bit integer, 64-bit integer, single-precision float and double-precision float. The integer kinds take their flags from the difference A minus B. The float kinds work directly on the raw IEEE-754 bit patterns and report an ordered relation.

A request is a one-cycle `valid_i` strobe together with a mode, operand A and operand B. On the next clock edge the unit registers the status word on `flags_o` and raises `done_o` for one cycle. Between requests `flags_o` keeps the last result.

Top module: `cmpf_unit`

## Requirements
- R1: The status word carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27 to 0 are always zero.
- R2: Mode 0 (32-bit integer) uses only bits 31:0 of each operand. Bits 63:32 have no effect on the result.
- R3: Mode 1 (64-bit integer) compares all 64 bits of each operand.
- R4: In the integer modes, Z is set when A minus B is zero, and N is set when that difference is negative as a signed number at the mode's width.
- R5: In the integer modes, V is set when A is negative, B is non-negative and the difference is non-negative. V is also set when A is non-negative, B is negative and the difference is negative. All signs are taken at the mode's width.
- R6: In the integer modes, C is the OR of three terms: (A negative AND B non-negative), (A negative AND difference non-negative), (B non-negative AND difference non-negative). This equals unsigned A >= B.
- R7: In mode 2 (single float) and mode 3 (double float), Z means A equals B, N means A is less than B, and C means A is greater than B. V is always zero in these modes.
- R8: Mode 2 reads each single-precision operand from bits 63:32. Bits 31:0 have no effect on the result.
- R9: In the float modes, +0 and -0 compare as equal.
- R10: In the float modes, if either operand is a NaN (exponent all ones and fraction non-zero), all four flags are zero. An infinity is ordered normally.
- R11: In the float modes, when both operands are negative, the one with the larger magnitude is the smaller value.
- R12: `flags_o` takes the new result on the clock edge after a `valid_i` strobe, and `done_o` is high for exactly the cycle that follows each strobe. Without a strobe, `flags_o` holds its value.
- R13: While `rst` is high and right after it, `flags_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare request strobe |
| mode_i | input | 2 | 0 int32, 1 int64, 2 single float, 3 double float |
| opa_i | input | 64 | Operand A register entry |
| opb_i | input | 64 | Operand B register entry |
| flags_o | output | 32 | Registered status word |
| done_o | output | 1 | One-cycle result pulse |

## Verification
The assertions assume that `mode_i` is known whenever `valid_i` is high and that a request lasts exactly one cycle. They also take reset as the only event that clears the result register. The stimulus drives every request for a single cycle on the falling edge. It covers all four mode codes with non-NaN, NaN and signed-zero patterns, and it puts deliberate garbage in the unused operand halves. It also sends back-to-back strobes, so the rule that the float flags are at most one-hot is exercised across successive results.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  typedef enum logic [1:0] {
    MODE_I32 = 2'd0,
    MODE_I64 = 2'd1,
    MODE_F32 = 2'd2,
    MODE_F64 = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_CNT = 4;

endpackage

// File: rtl/cmpf_int.sv
module cmpf_int
  import cmpf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output nzcv_t        f_o
);

  logic [W-1:0] diff;
  logic         sa, sb, sr;

  always_comb begin
    diff = a_i - b_i;
    sa   = a_i[W-1];
    sb   = b_i[W-1];
    sr   = diff[W-1];
    f_o.z = (diff == '0);
    f_o.n = sr;
    f_o.v = (sa & ~sb & ~sr) | (~sa & sb & sr);
    f_o.c = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
  end

endmodule

// File: rtl/cmpf_fp.sv
module cmpf_fp
  import cmpf_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  output nzcv_t                f_o
);

  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int MAG = W - 1;

  logic           sa, sb;
  logic [MAG-1:0] ma, mb;
  logic           nan_a, nan_b, both_zero, mag_lt, mag_eq, eq, lt;

  always_comb begin
    sa        = a_i[W-1];
    sb        = b_i[W-1];
    ma        = a_i[MAG-1:0];
    mb        = b_i[MAG-1:0];
    nan_a     = (&a_i[MAG-1:MAN_W]) & (|a_i[MAN_W-1:0]);
    nan_b     = (&b_i[MAG-1:MAN_W]) & (|b_i[MAN_W-1:0]);
    both_zero = ~(|ma) & ~(|mb);
    mag_lt    = ma < mb;
    mag_eq    = ma == mb;
    eq        = both_zero | (mag_eq & (sa == sb));
    if (eq)             lt = 1'b0;
    else if (sa != sb)  lt = sa;
    else if (!sa)       lt = mag_lt;
    else                lt = ~mag_lt & ~mag_eq;
    f_o.v = 1'b0;
    if (nan_a | nan_b) begin
      f_o.z = 1'b0;
      f_o.n = 1'b0;
      f_o.c = 1'b0;
    end else begin
      f_o.z = eq;
      f_o.n = lt;
      f_o.c = ~eq & ~lt;
    end
  end

endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HOST_W = 32,
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [HOST_W-1:0] flags_o,
  output logic              done_o
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SP_W   = 1 + SP_EXP + SP_MAN;
  localparam int DP_W   = 1 + DP_EXP + DP_MAN;

  nzcv_t f_i32, f_i64, f_f32, f_f64, f_sel;
  logic [HOST_W-1:0] word;

  cmpf_int #(.W(HALF_W)) u_i32 (
    .a_i(opa_i[HALF_W-1:0]), .b_i(opb_i[HALF_W-1:0]), .f_o(f_i32));

  cmpf_int #(.W(DATA_W)) u_i64 (
    .a_i(opa_i), .b_i(opb_i), .f_o(f_i64));

  cmpf_fp #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_f32 (
    .a_i(opa_i[DATA_W-1 -: SP_W]), .b_i(opb_i[DATA_W-1 -: SP_W]), .f_o(f_f32));

  cmpf_fp #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_f64 (
    .a_i(opa_i[DP_W-1:0]), .b_i(opb_i[DP_W-1:0]), .f_o(f_f64));

  always_comb begin
    unique case (cmp_mode_e'(mode_i))
      MODE_I32: f_sel = f_i32;
      MODE_I64: f_sel = f_i64;
      MODE_F32: f_sel = f_f32;
      default:  f_sel = f_f64;
    endcase
    word = '0;
    word[HOST_W-1 -: FLAG_CNT] = f_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) flags_o <= word;
    end
  end

endmodule

// File: rtl/cmpf_unit_chk.sv
module cmpf_unit_chk #(
  parameter int HOST_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [HOST_W-1:0] flags_o,
  input logic              done_o
);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flags_o[HOST_W-5:0] == '0);

  // R12
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_o));

  // R4
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
    flags_o[HOST_W-2] |-> !flags_o[HOST_W-1]);

  // R7
  float_v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i >= 2'd2) |=> !flags_o[HOST_W-4]);

  // R7
  float_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i >= 2'd2) |=> $onehot0(flags_o[HOST_W-1 -: 3]));

endmodule

bind cmpf_unit cmpf_unit_chk #(.HOST_W(HOST_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
  .flags_o(flags_o), .done_o(done_o));

// File: tb/cmpf_unit_test.sv
`timescale 1ns/1ps
module cmpf_unit_test;

  localparam int NV = 20;
  localparam int VW = 2 + 64 + 64 + 4;

  // {mode, A, B, expected NZCV}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 64'h0000000000000005, 64'h0000000000000003, 4'h2},
    {2'd0, 64'h0000000000000003, 64'h0000000000000005, 4'h8},
    {2'd0, 64'hFFFFFFFF00000007, 64'h0000000000000007, 4'h6},
    {2'd0, 64'h000000007FFFFFFF, 64'h00000000FFFFFFFF, 4'h9},
    {2'd0, 64'h0000000080000000, 64'h0000000000000001, 4'h3},
    {2'd1, 64'h0000000100000000, 64'h0000000000000001, 4'h2},
    {2'd1, 64'h0000000000000001, 64'h0000000000000002, 4'h8},
    {2'd1, 64'h8000000000000000, 64'h0000000000000001, 4'h3},
    {2'd2, 64'h4000000000000000, 64'h3F80000000000000, 4'h2},
    {2'd2, 64'h3F80000000000000, 64'h4000000000000000, 4'h8},
    {2'd2, 64'h3F80000000000000, 64'h3F80000000000000, 4'h4},
    {2'd2, 64'h0000000000000000, 64'h8000000000000000, 4'h4},
    {2'd2, 64'h7FC0000000000000, 64'h3F80000000000000, 4'h0},
    {2'd2, 64'hC000000000000000, 64'hBF80000000000000, 4'h8},
    {2'd2, 64'hBF80000000000000, 64'h3F80000000000000, 4'h8},
    {2'd3, 64'h4000000000000000, 64'h3FF0000000000000, 4'h2},
    {2'd3, 64'hBFF0000000000000, 64'hC000000000000000, 4'h2},
    {2'd3, 64'h7FF8000000000000, 64'h0000000000000000, 4'h0},
    {2'd3, 64'h7FF0000000000000, 64'h3FF0000000000000, 4'h2},
    {2'd2, 64'h3F800000FFFFFFFF, 64'h3F80000000000000, 4'h4}
  };

  string tags [NV] = '{"R6", "R4", "R2", "R5", "R5", "R3", "R3", "R3",
                       "R7", "R7", "R7", "R9", "R10", "R11", "R7",
                       "R7", "R11", "R10", "R10", "R8"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [31:0] flags_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  cmpf_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .opa_i(opa_i), .opb_i(opb_i), .flags_o(flags_o), .done_o(done_o));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; opa_i = a; opb_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", flags_o, 32'h0);
    check("R13", {31'h0, done_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R13", {31'h0, done_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      issue(e[VW-1 -: 2], e[131:68], e[67:4]);
      check(tags[i], flags_o, {e[3:0], 28'h0});
      check("R12", {31'h0, done_o}, 32'h1);
    end

    // R12: hold without strobe, done drops
    issue(2'd0, 64'h5, 64'h3);
    mode_i = 2'd1; opa_i = 64'h1; opb_i = 64'h9;
    @(negedge clk);
    check("R12", flags_o, 32'h2000_0000);
    check("R12", {31'h0, done_o}, 32'h0);

    // R12: back-to-back strobes
    @(negedge clk);
    valid_i = 1'b1; mode_i = 2'd0; opa_i = 64'h1; opb_i = 64'h1;
    @(negedge clk);
    check("R12", flags_o, 32'h6000_0000);
    mode_i = 2'd3; opa_i = 64'h7FF8000000000001; opb_i = 64'h0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R10", flags_o, 32'h0);
    check("R12", {31'h0, done_o}, 32'h1);

    // R13: reset mid-run clears result
    issue(2'd0, 64'h3, 64'h5);
    rst = 1'b1;
    @(negedge clk);
    check("R13", flags_o, 32'h0);
    check("R13", {31'h0, done_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule